// File: doc/BRIEF.md
# Two-Port Mailbox RAM with Cross-Port Interrupt Flags

This block is a shared memory of 9-bit words with two fully independent synchronous ports, called left and right. Each port can read or write any word on any cycle. The two topmost words of the address space are ordinary storage that also serve as mailboxes. The word at the highest address belongs to the right port. The word just below it belongs to the left port.

When one port writes its partner's mailbox, the partner's interrupt flag is raised. The partner sees the flag on an active-low output. It drops the flag by accessing its own mailbox with chip enable and output enable both low, and it normally reads the message in the same access. Each port also receives a busy input from an external arbiter. While a port's busy input is low, that port's writes are inhibited, and they can therefore raise no flag.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is low, both interrupt outputs are high and both read-data outputs are zero.
- R2: A port with chip enable low and read/write low stores its write data at its address. A port with chip enable low, output enable low and read/write high presents that word on its read data one cycle later. Read data holds its value on any cycle without a read.
- R3: A right-port write to address 2^AW-2 drives the left interrupt output low from the following cycle.
- R4: A left-port write to address 2^AW-1 drives the right interrupt output low from the following cycle. A right-port write to its own mailbox at 2^AW-1 leaves both flags unchanged.
- R5: A port clears its own flag, so that its interrupt output returns high in the following cycle, by taking chip enable and output enable low at its mailbox address. The left mailbox is at 2^AW-2 and the right mailbox is at 2^AW-1. The level of read/write does not matter for the clear.
- R6: When a flag is set and cleared in the same cycle, the set wins and the interrupt output is low afterwards.
- R7: While a port's busy input is low, its writes change neither the memory nor the partner's interrupt flag.
- R8: Mailbox words hold user data like any other location. A read in the same cycle as a write to the same word returns the word's previous contents.
- R9: Both ports may read the same word in the same cycle and both receive it. When both ports write the same address in one cycle, the left port's data is kept.
- R10: With chip enable high, a port neither writes, reads nor clears its flag, whatever its other controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| lf_cs_n | input | 1 | Left chip enable, active low |
| lf_oe_n | input | 1 | Left output enable, active low |
| lf_we_n | input | 1 | Left read/write: low writes, high reads |
| lf_addr | input | AW | Left word address |
| lf_wdata | input | DW | Left write data |
| lf_busy_n | input | 1 | Left busy from arbiter, low inhibits writes |
| lf_rdata | output | DW | Left read data, registered |
| lf_irq_n | output | 1 | Left interrupt, active low |
| rt_cs_n | input | 1 | Right chip enable, active low |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_we_n | input | 1 | Right read/write: low writes, high reads |
| rt_addr | input | AW | Right word address |
| rt_wdata | input | DW | Right write data |
| rt_busy_n | input | 1 | Right busy from arbiter, low inhibits writes |
| rt_rdata | output | DW | Right read data, registered |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench uses the default build: AW of 6, which gives 64 words and mailboxes at 62 and 63, and DW of 9. A small address space keeps both mailboxes and ordinary words within a short vector table. Every flag interaction can then be driven from plain addresses: set and clear in one cycle, a clear with read/write low, a write to a port's own mailbox, and a chip-enable-high access at a mailbox. Full 9-bit data patterns show that mailbox contents survive unchanged.

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_cs_n,
  input  logic          lf_oe_n,
  input  logic          lf_we_n,
  input  logic [AW-1:0] lf_addr,
  input  logic [DW-1:0] lf_wdata,
  input  logic          lf_busy_n,
  output logic [DW-1:0] lf_rdata,
  output logic          lf_irq_n,
  input  logic          rt_cs_n,
  input  logic          rt_oe_n,
  input  logic          rt_we_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_wdata,
  input  logic          rt_busy_n,
  output logic [DW-1:0] rt_rdata,
  output logic          rt_irq_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MBOX_R = AW'(DEPTH - 1);
  localparam logic [AW-1:0] MBOX_L = AW'(DEPTH - 2);

  logic [DW-1:0] mem [DEPTH];
  logic lf_flag, rt_flag;

  wire lf_wr  = !lf_cs_n && !lf_we_n && lf_busy_n;
  wire rt_wr  = !rt_cs_n && !rt_we_n && rt_busy_n;
  wire lf_rd  = !lf_cs_n && !lf_oe_n && lf_we_n;
  wire rt_rd  = !rt_cs_n && !rt_oe_n && rt_we_n;
  wire lf_acc = !lf_cs_n && !lf_oe_n;
  wire rt_acc = !rt_cs_n && !rt_oe_n;

  wire set_l = rt_wr  && (rt_addr == MBOX_L);
  wire clr_l = lf_acc && (lf_addr == MBOX_L);
  wire set_r = lf_wr  && (lf_addr == MBOX_R);
  wire clr_r = rt_acc && (rt_addr == MBOX_R);

  // right first, left last: left data survives a same-address collision
  always_ff @(posedge clk) begin
    if (rt_wr) mem[rt_addr] <= rt_wdata;
    if (lf_wr) mem[lf_addr] <= lf_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_rdata <= '0;
      rt_rdata <= '0;
    end else begin
      if (lf_rd) lf_rdata <= mem[lf_addr];
      if (rt_rd) rt_rdata <= mem[rt_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_flag <= 1'b0;
      rt_flag <= 1'b0;
    end else begin
      if (set_l)      lf_flag <= 1'b1;
      else if (clr_l) lf_flag <= 1'b0;
      if (set_r)      rt_flag <= 1'b1;
      else if (clr_r) rt_flag <= 1'b0;
    end
  end

  assign lf_irq_n = !lf_flag;
  assign rt_irq_n = !rt_flag;

  p_lset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_cs_n && !rt_we_n && rt_busy_n && rt_addr == MBOX_L) |=> !lf_irq_n);

  p_rset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lf_cs_n && !lf_we_n && lf_busy_n && lf_addr == MBOX_R) |=> !rt_irq_n);

  p_lclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lf_cs_n && !lf_oe_n && lf_addr == MBOX_L &&
     !(!rt_cs_n && !rt_we_n && rt_busy_n && rt_addr == MBOX_L)) |=> lf_irq_n);

  p_rclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_cs_n && !rt_oe_n && rt_addr == MBOX_R &&
     !(!lf_cs_n && !lf_we_n && lf_busy_n && lf_addr == MBOX_R)) |=> rt_irq_n);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_busy_n && !(!lf_cs_n && !lf_oe_n && lf_addr == MBOX_L)) |=> $stable(lf_irq_n));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lf_cs_n && !lf_oe_n && lf_we_n) |=> $stable(lf_rdata));
endmodule

// File: tb/mbox_dpram_tb_top.sv
`timescale 1ns/1ps
module mbox_dpram_tb_top;
  localparam int AW = 6;
  localparam int DW = 9;
  localparam int NV = 20;
  localparam logic [5:0] ML = 6'd62;
  localparam logic [5:0] MR = 6'd63;
  localparam logic [2:0] IDL = 3'b111, WR = 3'b010, RD = 3'b001, AX = 3'b000, NCS = 3'b100;

  // {lctl,laddr,lwd, rctl,raddr,rwd, exp lirq_n, exp rirq_n, exp lrd, exp rrd}
  localparam logic [55:0] VEC [NV] = '{
    {IDL==IDL ? WR : WR, 6'd5, 9'h1A5, IDL, 6'd0, 9'h000, 2'b11, 9'h000, 9'h000},
    {IDL, 6'd0, 9'h000, WR, 6'd9, 9'h0F3, 2'b11, 9'h000, 9'h000},
    {RD,  6'd9, 9'h000, RD, 6'd5, 9'h000, 2'b11, 9'h0F3, 9'h1A5},
    {RD,  6'd5, 9'h000, RD, 6'd5, 9'h000, 2'b11, 9'h1A5, 9'h1A5},
    {WR,  6'd7, 9'h111, WR, 6'd7, 9'h022, 2'b11, 9'h1A5, 9'h1A5},
    {RD,  6'd7, 9'h000, RD, 6'd7, 9'h000, 2'b11, 9'h111, 9'h111},
    {WR,  MR,   9'h155, IDL, 6'd0, 9'h000, 2'b10, 9'h111, 9'h111},
    {IDL, 6'd0, 9'h000, IDL, 6'd0, 9'h000, 2'b10, 9'h111, 9'h111},
    {IDL, 6'd0, 9'h000, RD, MR,   9'h000, 2'b11, 9'h111, 9'h155},
    {IDL, 6'd0, 9'h000, WR, ML,   9'h0AA, 2'b01, 9'h111, 9'h155},
    {AX,  ML,   9'h0AA, IDL, 6'd0, 9'h000, 2'b11, 9'h111, 9'h155},
    {RD,  ML,   9'h000, IDL, 6'd0, 9'h000, 2'b11, 9'h0AA, 9'h155},
    {RD,  ML,   9'h000, WR, ML,   9'h0BB, 2'b01, 9'h0AA, 9'h155},
    {RD,  ML,   9'h000, IDL, 6'd0, 9'h000, 2'b11, 9'h0BB, 9'h155},
    {WR,  MR,   9'h101, RD, MR,   9'h000, 2'b10, 9'h0BB, 9'h155},
    {IDL, 6'd0, 9'h000, RD, MR,   9'h000, 2'b11, 9'h0BB, 9'h101},
    {IDL, 6'd0, 9'h000, WR, ML,   9'h0CC, 2'b01, 9'h0BB, 9'h101},
    {NCS, ML,   9'h1FF, IDL, 6'd0, 9'h000, 2'b01, 9'h0BB, 9'h101},
    {RD,  ML,   9'h000, IDL, 6'd0, 9'h000, 2'b11, 9'h0CC, 9'h101},
    {IDL, 6'd0, 9'h000, WR, MR,   9'h033, 2'b11, 9'h0CC, 9'h101}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lf_cs_n = 1, lf_oe_n = 1, lf_we_n = 1, lf_busy_n = 1;
  logic rt_cs_n = 1, rt_oe_n = 1, rt_we_n = 1, rt_busy_n = 1;
  logic [AW-1:0] lf_addr = '0, rt_addr = '0;
  logic [DW-1:0] lf_wdata = '0, rt_wdata = '0;
  logic [DW-1:0] lf_rdata, rt_rdata;
  logic lf_irq_n, rt_irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_dpram #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lf_cs_n(lf_cs_n), .lf_oe_n(lf_oe_n), .lf_we_n(lf_we_n), .lf_addr(lf_addr),
    .lf_wdata(lf_wdata), .lf_busy_n(lf_busy_n), .lf_rdata(lf_rdata), .lf_irq_n(lf_irq_n),
    .rt_cs_n(rt_cs_n), .rt_oe_n(rt_oe_n), .rt_we_n(rt_we_n), .rt_addr(rt_addr),
    .rt_wdata(rt_wdata), .rt_busy_n(rt_busy_n), .rt_rdata(rt_rdata), .rt_irq_n(rt_irq_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string row_req(int i);
    case (i)
      0, 1, 2, 7: return "R2";
      3, 4, 5:    return "R9";
      6, 14:      return "R4";
      9, 16:      return "R3";
      8, 10, 11, 13, 15: return "R5";
      12:         return "R6";
      17, 18:     return "R10";
      default:    return "R8";
    endcase
  endfunction

  task automatic drive(logic [2:0] lc, logic [5:0] la, logic [8:0] lw,
                       logic [2:0] rc, logic [5:0] ra, logic [8:0] rw);
    {lf_cs_n, lf_oe_n, lf_we_n} = lc; lf_addr = la; lf_wdata = lw;
    {rt_cs_n, rt_oe_n, rt_we_n} = rc; rt_addr = ra; rt_wdata = rw;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_up();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "lf_irq_n", lf_irq_n, 1);
    chk("R1", "rt_irq_n", rt_irq_n, 1);
    chk("R1", "lf_rdata", lf_rdata, 0);
    chk("R1", "rt_rdata", rt_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][55:53], VEC[i][52:47], VEC[i][46:38],
            VEC[i][37:35], VEC[i][34:29], VEC[i][28:20]);
      chk(row_req(i), $sformatf("row %0d lf_irq_n", i), lf_irq_n, VEC[i][19]);
      chk(row_req(i), $sformatf("row %0d rt_irq_n", i), rt_irq_n, VEC[i][18]);
      chk(row_req(i), $sformatf("row %0d lf_rdata", i), lf_rdata, VEC[i][17:9]);
      chk(row_req(i), $sformatf("row %0d rt_rdata", i), rt_rdata, VEC[i][8:0]);
    end

    // R7: right busy low blocks both the mailbox write and the left flag
    rt_busy_n = 1'b0;
    drive(IDL, 6'd0, 9'h0, WR, ML, 9'h1EE);
    chk("R7", "lf_irq_n after busy write", lf_irq_n, 1);
    rt_busy_n = 1'b1;
    drive(RD, ML, 9'h0, IDL, 6'd0, 9'h0);
    chk("R7", "left mailbox after busy write", lf_rdata, 9'h0CC);

    // R7: left busy low blocks the right flag and the store
    lf_busy_n = 1'b0;
    drive(WR, MR, 9'h077, IDL, 6'd0, 9'h0);
    chk("R7", "rt_irq_n after busy write", rt_irq_n, 1);
    lf_busy_n = 1'b1;
    drive(IDL, 6'd0, 9'h0, RD, MR, 9'h0);
    chk("R7", "right mailbox after busy write", rt_rdata, 9'h033);

    // R8: mailbox word read by the writer's own port too
    drive(RD, MR, 9'h0, IDL, 6'd0, 9'h0);
    chk("R8", "left reads right mailbox", lf_rdata, 9'h033);

    // R1: reset in mid-run clears raised flags and read data
    drive(WR, MR, 9'h044, WR, ML, 9'h055);
    chk("R3", "lf_irq_n before reset", lf_irq_n, 0);
    chk("R4", "rt_irq_n before reset", rt_irq_n, 0);
    drive(IDL, 6'd0, 9'h0, IDL, 6'd0, 9'h0);
    rst_n = 1'b0;
    #1;
    chk("R1", "lf_irq_n in reset", lf_irq_n, 1);
    chk("R1", "rt_irq_n in reset", rt_irq_n, 1);
    chk("R1", "lf_rdata in reset", lf_rdata, 0);
    chk("R1", "rt_rdata in reset", rt_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_up();
  end
endmodule